// File: doc/BRIEF.md
# Module Clock Gate Controller

This block controls the functional clock of a single peripheral. Software drives it through a plain 32-bit register port with three words. The first is a control word holding the requested module mode and an optional debounce-clock enable, and it reports the module's idle status. The second is a clock-domain word that requests a software wakeup and reports which domain clocks are running. The third is a two-bit source-select word that picks the clock that feeds the peripheral.

Requests are not acknowledged at once. Each mode write or domain write starts a timed handshake. The idle-status field and the domain activity flags only settle when that handshake ends, so software polls the status to learn when the clock is usable or gone. The gate enable, the debounce enable, the wakeup request and the source selection leave the block as plain level outputs, and a clock-gating cell elsewhere consumes them.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the control word reads 0x0003_0000 (mode 0, idle status 3, debounce bit 0), the domain word reads 0, the source word reads 0, and fclk_en, dbclk_en, dom_wake and clk_src_sel are all 0.
- R2: A write to word 0 stores bits [1:0] as the mode, and a read of word 0 returns that value in bits [1:0] for every code 0..3. Code 2 drives fclk_en high on the clock edge of the write. Any other code drives it low on that edge.
- R3: Writing mode 2 while idle status (word 0, bits [17:16]) is not 0 sets idle status to 1 on the write edge. Idle status becomes 0 exactly MOD_LAT cycles after the write edge and stays 1 in every cycle before that. Idle status never takes the value 2.
- R4: Writing any mode other than 2 leaves idle status unchanged until MOD_LAT cycles after the write edge, when it becomes 3.
- R5: Idle status changes to 0 only while the stored mode is 2.
- R6: Bit 18 of word 0 is the debounce-clock enable. It is written in the same access as the mode, reads back as written and drives dbclk_en.
- R7: Writing 2 to bits [1:0] of word 1 requests a domain wakeup. The field reads back as written, and dom_wake is high while it holds 2. Bit 4 of word 1 (interface clock active) becomes 1 exactly DOM_LAT cycles after the write edge.
- R8: Bits 5 and 6 of word 1 (extra domain clocks active) become 1 exactly DOM_LAT+XTRA_LAG cycles after a wakeup write, never before bit 4.
- R9: Writing a value other than 2 to word 1 clears bit 4 exactly DOM_LAT cycles after the write edge, and clears bits 5 and 6 exactly DOM_LAT+XTRA_LAG cycles after it.
- R10: Word 2 bits [1:0] select the clock source: 0 external pin clock, 1 main oscillator, 2 32 kHz clock. Writes of 0, 1 and 2 read back and appear on clk_src_sel after the write edge.
- R11: A write of 3 to word 2 is ignored. The previous selection stays in the read-back and on clk_src_sel.
- R12: A new mode write made while a handshake is still running restarts the MOD_LAT count from the new write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and handshake clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Word index: 0 control, 1 domain, 2 source; 3 reads 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| fclk_en | output | 1 | Functional clock gate enable |
| dbclk_en | output | 1 | Debounce clock enable |
| dom_wake | output | 1 | Software wakeup request to the clock domain |
| clk_src_sel | output | 2 | Clock source multiplexer select |

## Verification
Each result has a fixed due cycle. The mode field, debounce bit, source select, wakeup request and idle value 1 are due on the write edge itself. Idle status 0 or 3 is due MOD_LAT edges after the write edge. Bit 4 is due DOM_LAT edges after a domain write, and bits 5 and 6 are due DOM_LAT+XTRA_LAG edges after it. The bench drives every write on a falling edge and counts falling edges from the edge that takes the write. It checks each status field one edge before its due cycle, to see the old value, and again at the due cycle, to see the new one. All reads are sampled 1 ns after a falling edge, far from any rising edge.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

  // word index decode
  localparam logic [1:0] A_MOD = 2'd0;
  localparam logic [1:0] A_DOM = 2'd1;
  localparam logic [1:0] A_SRC = 2'd2;

  // mode and idle encodings
  localparam logic [1:0] MODE_ON    = 2'd2;
  localparam logic [1:0] IDLE_FUNC  = 2'd0;
  localparam logic [1:0] IDLE_TRANS = 2'd1;
  localparam logic [1:0] IDLE_OFF   = 2'd3;

  // domain and source encodings
  localparam logic [1:0] DOM_WAKE = 2'd2;
  localparam logic [1:0] SRC_RSVD = 2'd3;

  // bit positions
  localparam int MODE_LSB  = 0;
  localparam int IDLE_LSB  = 16;
  localparam int DBCLK_BIT = 18;
  localparam int IFC_BIT   = 4;
  localparam int XCLK_LSB  = 5;

  function automatic logic [31:0] pack_mod(input logic [1:0] mode,
                                           input logic [1:0] idle,
                                           input logic       db);
    logic [31:0] w;
    w = '0;
    w[MODE_LSB +: 2] = mode;
    w[IDLE_LSB +: 2] = idle;
    w[DBCLK_BIT]     = db;
    return w;
  endfunction

  function automatic logic [31:0] pack_dom(input logic [1:0] field,
                                           input logic       ifc,
                                           input logic [1:0] xclk);
    logic [31:0] w;
    w = '0;
    w[1:0]           = field;
    w[IFC_BIT]       = ifc;
    w[XCLK_LSB +: 2] = xclk;
    return w;
  endfunction

  function automatic logic src_legal(input logic [1:0] v);
    return v != SRC_RSVD;
  endfunction

endpackage

// File: rtl/ckg_hs_timer.sv
module ckg_hs_timer #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  localparam int unsigned CW = $clog2(DELAY + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  // fire marks the edge on which the waiting state must settle
  assign fire = busy && (cnt == CW'(DELAY)) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(1);
    end else if (busy) begin
      if (fire) busy <= 1'b0;
      else      cnt  <= cnt + CW'(1);
    end
  end

  AST_TMR_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !fire);  // R12

endmodule

// File: rtl/ckg_idle_seq.sv
module ckg_idle_seq
  import ckg_pkg::*;
#(
  parameter int unsigned MOD_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_on,
  output logic [1:0] idle
);
  logic fire;
  logic tgt_on;

  ckg_hs_timer #(.DELAY(MOD_LAT)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(req),
    .fire (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle   <= IDLE_OFF;
      tgt_on <= 1'b0;
    end else if (req) begin
      tgt_on <= req_on;
      if (req_on && idle != IDLE_FUNC) idle <= IDLE_TRANS;
    end else if (fire) begin
      idle <= tgt_on ? IDLE_FUNC : IDLE_OFF;
    end
  end

  AST_IDLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    idle != 2'd2);  // R3
  AST_IDLE_TRANS_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_on && idle != IDLE_FUNC) |=> idle == IDLE_TRANS);  // R3

endmodule

// File: rtl/ckg_domain.sv
module ckg_domain
  import ckg_pkg::*;
#(
  parameter int unsigned DOM_LAT  = 3,
  parameter int unsigned XTRA_LAG = 2,
  parameter int unsigned N_XTRA   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       req_wake,
  output logic       ifc_act,
  output logic [1:0] x_act
);
  localparam logic [1:0] XMASK = (N_XTRA >= 2) ? 2'b11 :
                                 (N_XTRA == 1) ? 2'b01 : 2'b00;

  logic tgt;
  logic fire_ifc;

  ckg_hs_timer #(.DELAY(DOM_LAT)) u_tmr_ifc (
    .clk  (clk),
    .rst_n(rst_n),
    .start(req),
    .fire (fire_ifc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt     <= 1'b0;
      ifc_act <= 1'b0;
    end else begin
      if (req) tgt <= req_wake;
      if (fire_ifc) ifc_act <= tgt;
    end
  end

  generate
    if (N_XTRA > 0) begin : g_xtra
      logic fire_x;
      ckg_hs_timer #(.DELAY(DOM_LAT + XTRA_LAG)) u_tmr_x (
        .clk  (clk),
        .rst_n(rst_n),
        .start(req),
        .fire (fire_x)
      );
      always_ff @(posedge clk) begin
        if (!rst_n)      x_act <= 2'b00;
        else if (fire_x) x_act <= tgt ? XMASK : 2'b00;
      end

      AST_XTRA_AFTER_IFC: assert property (@(posedge clk) disable iff (!rst_n)
        (x_act != 2'b00 && $past(x_act) == 2'b00) |-> ifc_act);  // R8
    end else begin : g_noxtra
      assign x_act = 2'b00;
    end
  endgenerate

endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import ckg_pkg::*;
#(
  parameter int unsigned MOD_LAT   = 4,
  parameter int unsigned DOM_LAT   = 3,
  parameter int unsigned XTRA_LAG  = 2,
  parameter int unsigned N_XTRA    = 2,
  parameter bit          HAS_DBCLK = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        fclk_en,
  output logic        dbclk_en,
  output logic        dom_wake,
  output logic [1:0]  clk_src_sel
);
  logic [1:0] mode_q;
  logic       db_q;
  logic [1:0] dom_q;
  logic [1:0] src_q;
  logic [1:0] idle;
  logic       ifc_act;
  logic [1:0] x_act;

  // named write events
  logic wr_mod, wr_dom, wr_src, src_ok;
  assign wr_mod = bus_wr && bus_addr == A_MOD;
  assign wr_dom = bus_wr && bus_addr == A_DOM;
  assign wr_src = bus_wr && bus_addr == A_SRC;
  assign src_ok = src_legal(bus_wdata[1:0]);

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{bus_wdata[31:19], bus_wdata[17:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      db_q   <= 1'b0;
      dom_q  <= 2'd0;
      src_q  <= 2'd0;
    end else begin
      if (wr_mod) begin
        mode_q <= bus_wdata[1:0];
        db_q   <= HAS_DBCLK ? bus_wdata[DBCLK_BIT] : 1'b0;
      end
      if (wr_dom) dom_q <= bus_wdata[1:0];
      if (wr_src && src_ok) src_q <= bus_wdata[1:0];
    end
  end

  ckg_idle_seq #(.MOD_LAT(MOD_LAT)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (wr_mod),
    .req_on(bus_wdata[1:0] == MODE_ON),
    .idle  (idle)
  );

  ckg_domain #(
    .DOM_LAT (DOM_LAT),
    .XTRA_LAG(XTRA_LAG),
    .N_XTRA  (N_XTRA)
  ) u_dom (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (wr_dom),
    .req_wake(bus_wdata[1:0] == DOM_WAKE),
    .ifc_act (ifc_act),
    .x_act   (x_act)
  );

  always_comb begin
    unique case (bus_addr)
      A_MOD:   bus_rdata = pack_mod(mode_q, idle, db_q);
      A_DOM:   bus_rdata = pack_dom(dom_q, ifc_act, x_act);
      A_SRC:   bus_rdata = {30'd0, src_q};
      default: bus_rdata = '0;
    endcase
  end

  assign fclk_en     = mode_q == MODE_ON;
  assign dbclk_en    = db_q;
  assign dom_wake    = dom_q == DOM_WAKE;
  assign clk_src_sel = src_q;

  AST_MODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mod |=> mode_q == $past(bus_wdata[1:0]));  // R2
  AST_FUNC_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (idle == IDLE_FUNC && $past(idle) != IDLE_FUNC) |-> mode_q == MODE_ON);  // R5
  AST_OFF_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (idle == IDLE_OFF && $past(idle) != IDLE_OFF) |-> mode_q != MODE_ON);  // R4
  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    clk_src_sel != SRC_RSVD);  // R11
  AST_SRC_HOLD_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_src && bus_wdata[1:0] == SRC_RSVD) |=> $stable(clk_src_sel));  // R11

endmodule

// File: tb/tb_clk_gate_ctrl.sv
module tb_clk_gate_ctrl;
  localparam int ML = 4;
  localparam int DL = 3;
  localparam int XL = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fclk_en, dbclk_en, dom_wake;
  logic [1:0]  clk_src_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clk_gate_ctrl #(.MOD_LAT(ML), .DOM_LAT(DL), .XTRA_LAG(XL), .N_XTRA(2),
                  .HAS_DBCLK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fclk_en(fclk_en),
    .dbclk_en(dbclk_en), .dom_wake(dom_wake), .clk_src_sel(clk_src_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // expected words built field by field
  function automatic logic [31:0] ctl(input logic [1:0] m, input logic [1:0] i, input logic b);
    return (32'(b) << 18) | (32'(i) << 16) | 32'(m);
  endfunction

  function automatic logic [31:0] dw(input logic [1:0] f, input logic i, input logic [1:0] x);
    return (32'(x) << 5) | (32'(i) << 4) | 32'(f);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0003_0000);
    rd(2'd1, d); chk("R1 dom", d, 32'h0);
    rd(2'd2, d); chk("R1 src", d, 32'h0);
    chk("R1 outs", {28'd0, fclk_en, dbclk_en, clk_src_sel}, 32'h0);
    chk("R1 wake", {31'd0, dom_wake}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(2'd0, 32'h0004_0002);
    rd(2'd0, d); chk("R3 idle 1 on write", d, ctl(2, 1, 1));
    chk("R2 fclk_en", {31'd0, fclk_en}, 32'd1);
    chk("R6 dbclk_en", {31'd0, dbclk_en}, 32'd1);
    step(ML - 1);
    rd(2'd0, d); chk("R3 idle 1 before due", d, ctl(2, 1, 1));
    step(1);
    rd(2'd0, d); chk("R3 R5 idle 0 at due", d, ctl(2, 0, 1));
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr(2'd0, 32'h0);
    chk("R2 fclk_en off", {31'd0, fclk_en}, 32'd0);
    chk("R6 dbclk cleared", {31'd0, dbclk_en}, 32'd0);
    step(ML - 1);
    rd(2'd0, d); chk("R4 idle held", d, ctl(0, 0, 0));
    step(1);
    rd(2'd0, d); chk("R4 idle 3 at due", d, ctl(0, 3, 0));
  endtask

  task automatic t_mode_echo();
    logic [31:0] d;
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, 32'(m));
      rd(2'd0, d); chk("R2 mode echo", d & 32'h3, 32'(m));
      chk("R2 fclk_en code", {31'd0, fclk_en}, {31'd0, m == 2});
    end
    wr(2'd0, 32'h0);
    step(ML + 1);
    rd(2'd0, d); chk("R4 settled off", d, ctl(0, 3, 0));
  endtask

  task automatic t_restart();
    logic [31:0] d;
    wr(2'd0, 32'h2);
    step(2);
    wr(2'd0, 32'h2);
    step(ML - 1);
    rd(2'd0, d); chk("R12 still 1 after restart", d, ctl(2, 1, 0));
    step(1);
    rd(2'd0, d); chk("R12 0 at restarted due", d, ctl(2, 0, 0));
    wr(2'd0, 32'h0);
    step(ML + 1);
  endtask

  task automatic t_domain();
    logic [31:0] d;
    wr(2'd1, 32'h2);
    rd(2'd1, d); chk("R7 field echo", d, dw(2, 0, 0));
    chk("R7 dom_wake", {31'd0, dom_wake}, 32'd1);
    step(DL - 1);
    rd(2'd1, d); chk("R7 ifc before due", d, dw(2, 0, 0));
    step(1);
    rd(2'd1, d); chk("R7 R8 ifc at due, extras low", d, dw(2, 1, 0));
    step(XL - 1);
    rd(2'd1, d); chk("R8 extras before due", d, dw(2, 1, 0));
    step(1);
    rd(2'd1, d); chk("R8 extras at due", d, dw(2, 1, 3));
    wr(2'd1, 32'h0);
    chk("R9 dom_wake off", {31'd0, dom_wake}, 32'd0);
    step(DL - 1);
    rd(2'd1, d); chk("R9 ifc held", d, dw(0, 1, 3));
    step(1);
    rd(2'd1, d); chk("R9 ifc cleared", d, dw(0, 0, 3));
    step(XL);
    rd(2'd1, d); chk("R9 extras cleared", d, dw(0, 0, 0));
  endtask

  task automatic t_source();
    logic [31:0] d;
    for (int s = 1; s >= 0; s--) begin
      wr(2'd2, 32'(s + 1));
      rd(2'd2, d); chk("R10 src echo", d, 32'(s + 1));
      chk("R10 src port", {30'd0, clk_src_sel}, 32'(s + 1));
    end
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk("R10 src pin", d, 32'h0);
    wr(2'd2, 32'h2);
    wr(2'd2, 32'h3);
    rd(2'd2, d); chk("R11 reserved ignored", d, 32'h2);
    chk("R11 port held", {30'd0, clk_src_sel}, 32'h2);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_enable();
    t_disable();
    t_mode_echo();
    t_restart();
    t_domain();
    t_source();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule